// File: doc/BRIEF.md
# Programmable Modular Pseudo-Random Sequence Generator

This block produces a pseudo-random serial bit stream from an 8-bit shift register with modular feedback. Each adjacent pair of register bits has its own XOR stage, so the feedback bit is folded into every tap position in the same clock. A polynomial value written by software sets both the effective register length and the tap positions. The highest set bit of the polynomial marks the top of the active register. The remaining set bits below it are the taps. This supports sequence lengths from 2 to 8 bits. For example, 30h gives a 63-state cycle on six bits and 8Eh gives a 255-state cycle on eight bits.

Software uses a small register port to reach the running state, the polynomial, a seed value and a control word with an enable bit. While the block is disabled, its state is frozen and its outputs are held low. In that condition a seed write initialises the running state, and the state can be read back through a two-read sequence. While the block is enabled, it shifts once per clock and emits the bit leaving the top active position. It also raises a one-cycle event whenever the running state returns to the seed value.

Top module: `prs_gen`

## Requirements
- R1: After reset, every register reads 0, and `seq_out` and `irq` are low.
- R2: Register addresses are as follows. Address 0 is the running state, and it ignores writes. Address 1 is the polynomial. Address 2 is the seed. Address 3 is the control word, where only bit 0 (enable) is kept and the upper bits read as 0. The polynomial and seed read back the value last written.
- R3: While disabled, a seed write also loads the running state with the written value ANDed with the active-length mask.
- R4: While enabled, on each clock with top bit f = state[L], the state is first XORed with the tap bits when f is 1. It is then shifted left by one with f entering bit 0, and masked to bits L..0.
- R5: While enabled, `seq_out` equals state[L] of the current state. While disabled, `seq_out` is 0.
- R6: Polynomial 30h with a nonzero seed returns to the seed after exactly 63 shifts. Polynomial 8Eh returns after exactly 255 shifts.
- R7: The active top position L is the index of the highest set polynomial bit. State bits above L always read as 0, including right after a polynomial write.
- R8: A read at address 0 returns 0. If that read occurs while disabled, a directly following read at address 1 returns the running state instead of the polynomial. Any other read in between cancels this.
- R9: While enabled, address 0 reads 0 and address 1 reads the polynomial, so the state stays hidden.
- R10: A seed write while enabled updates only the seed register. The running sequence continues undisturbed.
- R11: `irq` is high for the cycle after a shift that makes the state equal to the seed. It is low whenever the block is disabled.
- R12: While disabled, and without a seed or polynomial write, the running state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, which advances the readback sequence |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| seq_out | output | 1 | Serial pseudo-random bit |
| irq | output | 1 | Sequence-wrap event |

## Verification
The delicate overlap is a register write landing on the same clock edge as a live shift. A seed write while running must leave the shift untouched. A control write that clears enable still lets that edge shift once. The bench issues these writes in the middle of a running stream, advances its own model by the shift that shares the edge, and then compares the continuing serial stream cycle by cycle. After disabling, it recovers the final state through the two-read sequence and compares it with the model. The seed register is read back separately to show that the overlapping write was stored.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [1:0] {
        REG_STATE = 2'd0,
        REG_POLY  = 2'd1,
        REG_SEED  = 2'd2,
        REG_CTRL  = 2'd3
    } prs_addr_e;

endpackage

// File: rtl/prs_len_decode.sv
module prs_len_decode #(
    parameter int W = 8
) (
    input  logic [W-1:0] poly,
    output logic [W-1:0] len_mask,
    output logic [W-1:0] top_sel
);

    // bit i is active when any polynomial bit at or above i is set
    for (genvar i = 0; i < W; i++) begin : g_suffix
        assign len_mask[i] = |poly[W-1:i];
    end

    assign top_sel = len_mask & ~(len_mask >> 1);

endmodule

// File: rtl/prs_step.sv
module prs_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] state,
    input  logic [W-1:0] poly,
    input  logic [W-1:0] len_mask,
    input  logic [W-1:0] top_sel,
    output logic [W-1:0] next_state,
    output logic         fb
);

    logic [W-1:0] taps;
    logic [W-1:0] mixed;
    logic [W-1:0] shifted;

    always_comb begin
        fb         = |(state & top_sel);
        taps       = poly & ~top_sel;
        mixed      = fb ? (state ^ taps) : state;
        shifted    = {mixed[W-2:0], fb};
        next_state = shifted & len_mask;
    end

endmodule

// File: rtl/prs_rdmux.sv
module prs_rdmux
    import prs_pkg::*;
#(
    parameter int W = 8
) (
    input  prs_addr_e    addr,
    input  logic [W-1:0] state,
    input  logic [W-1:0] poly,
    input  logic [W-1:0] seed,
    input  logic         en,
    input  logic         armed,
    output logic [W-1:0] rdata
);

    always_comb begin
        unique case (addr)
            REG_STATE: rdata = '0;
            REG_POLY:  rdata = (armed && !en) ? state : poly;
            REG_SEED:  rdata = seed;
            REG_CTRL:  rdata = {{(W-1){1'b0}}, en};
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/prs_gen.sv
module prs_gen
    import prs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    input  logic         bus_rd,
    output logic [W-1:0] bus_rdata,
    output logic         seq_out,
    output logic         irq
);

    typedef struct packed {
        logic [W-1:0] state;
        logic [W-1:0] poly;
        logic [W-1:0] seed;
        logic         en;
        logic         armed;
        logic         irq;
    } prs_regs_t;

    prs_regs_t    r_d, r_q;
    prs_addr_e    addr;
    logic [W-1:0] cur_mask, cur_top;
    logic [W-1:0] new_mask, new_top;
    logic [W-1:0] step_next;
    logic         step_fb;
    logic         wr_poly, wr_seed, wr_ctrl;

    assign addr = prs_addr_e'(bus_addr);

    prs_len_decode #(.W(W)) i_cur_len (
        .poly     (r_q.poly),
        .len_mask (cur_mask),
        .top_sel  (cur_top)
    );

    prs_len_decode #(.W(W)) i_new_len (
        .poly     (bus_wdata),
        .len_mask (new_mask),
        .top_sel  (new_top)
    );

    prs_step #(.W(W)) i_step (
        .state      (r_q.state),
        .poly       (r_q.poly),
        .len_mask   (cur_mask),
        .top_sel    (cur_top),
        .next_state (step_next),
        .fb         (step_fb)
    );

    prs_rdmux #(.W(W)) i_rdmux (
        .addr  (addr),
        .state (r_q.state),
        .poly  (r_q.poly),
        .seed  (r_q.seed),
        .en    (r_q.en),
        .armed (r_q.armed),
        .rdata (bus_rdata)
    );

    always_comb begin
        wr_poly = bus_wr && (addr == REG_POLY);
        wr_seed = bus_wr && (addr == REG_SEED);
        wr_ctrl = bus_wr && (addr == REG_CTRL);

        r_d = r_q;

        if (r_q.en) begin
            r_d.state = step_next;
        end
        if (wr_poly) begin
            r_d.poly  = bus_wdata;
            r_d.state = r_d.state & new_mask;
        end
        if (wr_seed) begin
            r_d.seed = bus_wdata;
            if (!r_q.en) begin
                r_d.state = bus_wdata & cur_mask;
            end
        end
        if (wr_ctrl) begin
            r_d.en = bus_wdata[0];
        end
        if (bus_rd) begin
            r_d.armed = (addr == REG_STATE) && !r_q.en;
        end
        r_d.irq = r_q.en && (r_d.state == r_d.seed);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign seq_out = r_q.en & step_fb;
    assign irq     = r_q.en & r_q.irq;

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.en && wr_seed) |=> (r_q.state == ($past(bus_wdata) & $past(cur_mask)))) else $error("seed load"); // R3

    AST_STATE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en && (r_q.state != '0) && !bus_wr) |=> (r_q.state != '0)) else $error("state died"); // R4

    AST_ABOVE_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state & ~cur_mask) == '0)) else $error("bits above length"); // R7

    AST_ADDR0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && addr == REG_STATE) |-> (bus_rdata == '0)) else $error("addr0 read"); // R8

    AST_HIDDEN_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en && addr == REG_POLY) |-> (bus_rdata == r_q.poly)) else $error("state exposed"); // R9

    AST_SEED_NO_DISTURB: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en && wr_seed) |=> (r_q.state == $past(step_next))) else $error("seed disturbed run"); // R10

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (r_q.state == r_q.seed)) else $error("irq without match"); // R11

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.en && !wr_seed && !wr_poly) |=> $stable(r_q.state)) else $error("state moved"); // R12

endmodule

// File: tb/test_prs_gen.sv
module test_prs_gen;

    localparam int W = 8;
    localparam int NVEC = 6;
    // poly, seed, shift count
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h8E, 8'h01, 8'd40},
        {8'h30, 8'h21, 8'd70},
        {8'hB8, 8'h5A, 8'd30},
        {8'h03, 8'h03, 8'd5},
        {8'h0C, 8'hF7, 8'd12},
        {8'h8E, 8'hFF, 8'd20}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic         bus_rd = 1'b0;
    logic [W-1:0] bus_rdata;
    logic         seq_out;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prs_gen #(.W(W)) i_prs_gen (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .seq_out(seq_out), .irq(irq)
    );

    function automatic logic [W-1:0] m_mask(input logic [W-1:0] p);
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) m[i] = |(p >> i);
        return m;
    endfunction

    function automatic logic m_top(input logic [W-1:0] s, input logic [W-1:0] p);
        logic [W-1:0] m = m_mask(p);
        logic t = 1'b0;
        for (int i = 0; i < W; i++)
            if (m[i] && (i == W-1 || !m[i+1])) t = s[i];
        return t;
    endfunction

    function automatic logic [W-1:0] m_step(input logic [W-1:0] s, input logic [W-1:0] p);
        logic [W-1:0] m = m_mask(p);
        logic [W-1:0] topbit = m & ~(m >> 1);
        logic f = m_top(s, p);
        logic [W-1:0] t = f ? (s ^ (p & ~topbit)) : s;
        return ((t << 1) | {{(W-1){1'b0}}, f}) & m;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_state(output logic [W-1:0] v);
        logic [W-1:0] z;
        rd(2'd0, z);
        check(z == '0, "R8 addr0", z, 0);
        rd(2'd1, v);
    endtask

    initial begin : watchdog
        #900000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] v, st, p;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check(v == '0, "R1 reset read", v, 0);
        end
        check(!seq_out && !irq, "R1 outputs", {seq_out, irq}, 0);

        // R2 register map
        wr(2'd1, 8'h8E); rd(2'd1, v); check(v == 8'h8E, "R2 poly", v, 8'h8E);
        wr(2'd2, 8'h3C); rd(2'd2, v); check(v == 8'h3C, "R2 seed", v, 8'h3C);
        wr(2'd3, 8'hFE); rd(2'd3, v); check(v == 8'h00, "R2 ctrl", v, 0);
        wr(2'd0, 8'h77); rd_state(v); check(v == 8'h3C, "R2 state ignores write", v, 8'h3C);

        // table walk: R3 R4 R5 R8
        for (int n = 0; n < NVEC; n++) begin
            p = VEC[n][23:16];
            wr(2'd1, p);
            wr(2'd2, VEC[n][15:8]);
            st = VEC[n][15:8] & m_mask(p);
            rd_state(v);
            check(v == st, "R3 seed load", v, st);
            wr(2'd3, 8'h01);
            for (int i = 0; i < int'(VEC[n][7:0]); i++) begin
                check(seq_out == m_top(st, p), "R5 serial bit", seq_out, m_top(st, p));
                st = m_step(st, p);
                if (i == int'(VEC[n][7:0]) - 1) wr(2'd3, 8'h00);
                else @(negedge clk);
            end
            check(seq_out == 1'b0, "R5 low when disabled", seq_out, 0);
            rd_state(v);
            check(v == st, "R4 state after run", v, st);
        end

        // R7 bits above length
        wr(2'd1, 8'h0C); wr(2'd2, 8'hFF);
        rd_state(v); check(v == 8'h0F, "R7 masked seed", v, 8'h0F);
        wr(2'd1, 8'h03);
        rd_state(v); check(v == 8'h03, "R7 masked on poly write", v, 8'h03);

        // R8 sequence broken by another read
        wr(2'd1, 8'h8E); wr(2'd2, 8'h81);
        rd(2'd0, v); rd(2'd2, v); rd(2'd1, v);
        check(v == 8'h8E, "R8 broken sequence", v, 8'h8E);

        // R6 / R11 periods
        for (int s = 0; s < 2; s++) begin
            p = (s == 0) ? 8'h30 : 8'h8E;
            wr(2'd1, p); wr(2'd2, 8'h01);
            wr(2'd3, 8'h01);
            k = 0;
            while (!irq && k < 400) begin @(negedge clk); k++; end
            check(k == ((s == 0) ? 63 : 255), "R6 period", k, (s == 0) ? 63 : 255);
            @(negedge clk);
            check(!irq, "R11 one-cycle irq", irq, 0);
            wr(2'd3, 8'h00);
            check(!irq, "R11 low when disabled", irq, 0);
        end

        // R9 hidden while enabled, R10 seed write while enabled
        p = 8'h8E; wr(2'd1, p); wr(2'd2, 8'h01); st = 8'h01;
        wr(2'd3, 8'h01);
        for (int i = 0; i < 6; i++) begin
            check(seq_out == m_top(st, p), "R10 stream before", seq_out, m_top(st, p));
            st = m_step(st, p); @(negedge clk);
        end
        rd(2'd0, v); st = m_step(st, p); check(v == 0, "R9 addr0 enabled", v, 0);
        rd(2'd1, v); st = m_step(st, p); check(v == p, "R9 poly enabled", v, p);
        wr(2'd2, 8'h55); st = m_step(st, p);
        for (int i = 0; i < 10; i++) begin
            check(seq_out == m_top(st, p), "R10 stream after", seq_out, m_top(st, p));
            st = m_step(st, p);
            if (i == 9) wr(2'd3, 8'h00); else @(negedge clk);
        end
        rd(2'd2, v); check(v == 8'h55, "R10 seed stored", v, 8'h55);
        rd_state(v); check(v == st, "R10 state undisturbed", v, st);

        // R12 frozen while disabled
        repeat (5) @(negedge clk);
        rd_state(v); check(v == st, "R12 frozen", v, st);
        check(!seq_out && !irq, "R12 outputs low", {seq_out, irq}, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule